// File: doc/BRIEF.md
# 64-bit Interval Timer

This block is a memory-mapped interval timer with a 64-bit up-counter. Software reaches it through a 32-bit register bus. A selectable source strobe (the peripheral tick or an alternate, slower tick) goes through a 4-bit prescaler. Each prescaled tick advances the counter. When the counter reaches the programmed period, the timer raises a period event. In continuous operation it wraps to zero and keeps counting. In one-shot operation it stops.

The 64-bit period and counter are each reached as two 32-bit words. A write to the low period word commits the whole period from a shadow register. A read of the low counter word latches the upper half, so a later read of the high word belongs to the same sample. The status flag clears when it is read. The interrupt output is the flag gated by its enable.

Both time bases arrive as clock-enable strobes in the block's single clock domain. The alternate strobe is expected to come at most once every three peripheral strobes. The counter width is a parameter, and the two halves split it evenly.

Top module: `ivt64_timer`

## Requirements
- R1: After reset, every readable register (offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x1C, 0x20, 0x24) reads zero, the timer is idle and `irq` is low.
- R2: The selected source strobe is divided by the prescaler field (mode bits 11:8) plus one: a field of 0 advances the counter on every strobe and a field of 15 on every sixteenth strobe.
- R3: A write of 1 to control bit 0 starts an idle timer. With period P, the first period event occurs on the (P+1)×(pre+1)-th selected strobe after the start write, and it sets status bit 0 (offset 0x1C).
- R4: With mode bit 0 set (continuous), the counter wraps to zero at each period event and keeps running, so events repeat every (P+1)×(pre+1) selected strobes.
- R5: With mode bit 0 clear (one-shot), the timer stops after the first period event. Control bit 0 then reads 0, the counter reads 0, and no further event occurs until a new start.
- R6: Mode bit 3 selects the alternate strobe input as the count source instead of the peripheral strobe.
- R7: A write to the period high word (0x0C) only fills a shadow register. The active period, and its readback at 0x08 and 0x0C, changes only when the low word (0x08) is written.
- R8: A read of the counter low word (0x20) returns the low half of the live count and latches the high half. A read of 0x24 returns that latched half, however many cycles later it happens.
- R9: A read of the status register clears the flag, except when a period event falls in the same cycle. In that case the flag stays set.
- R10: `irq` is high exactly when the status flag is set and interrupt-enable bit 0 (offset 0x10) is set. With the enable clear, events still set the flag but `irq` stays low.
- R11: Writing control bit 8 performs a software reset. The timer stops, the counter, prescaler and flag clear, and the reset takes priority over a start bit in the same write. Mode, period and enable keep their values.

Ports and register offsets are byte offsets on `bus_addr`. An access is a single cycle with `bus_sel` high. `bus_wr` high means write. Read data is combinational on `bus_rdata`, and read side effects take place at the clock edge of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| periph_tick | input | 1 | Peripheral time-base strobe |
| alt_tick | input | 1 | Alternate time-base strobe |
| irq | output | 1 | Period interrupt request |

## Verification
The delicate collision is between a status read and a new period event in the same cycle. The bench runs a continuous timer with a short period. It computes the edge of the next event from the first one and places the status read's clock edge exactly on it. The flag and `irq` must then stay high, and a read one cycle later must clear them. A second overlap puts a start and a software reset in one write: the reset must win. Prescaler, period and mode are swept on a 16-bit counter, with strobe counts compared against (P+1)×(pre+1).

// File: rtl/ivt_pkg.sv
// Shared constants and types for the interval timer.
// Assumes a 32-bit register bus with byte offsets.
package ivt_pkg;

    localparam int BUS_W = 32;
    localparam int PRES_W = 4;

    // Register byte offsets.
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_MODE   = 'h04;
    localparam int OFF_PER_LO = 'h08;
    localparam int OFF_PER_HI = 'h0C;
    localparam int OFF_IEN    = 'h10;
    localparam int OFF_STAT   = 'h1C;
    localparam int OFF_CNT_LO = 'h20;
    localparam int OFF_CNT_HI = 'h24;

    // Field positions.
    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_RST_BIT  = 8;
    localparam int MODE_CONT_BIT = 0;
    localparam int MODE_ALT_BIT  = 3;
    localparam int MODE_PRE_LSB  = 8;

    typedef struct packed {
        logic [PRES_W-1:0] pres;
        logic              alt_src;
        logic              cont;
    } mode_cfg_t;

endpackage

// File: rtl/ivt_regs.sv
// Register file and bus decode of the interval timer.
// Assumes single-cycle accesses; read data is combinational and read side
// effects (status clear, high-half latch) happen at the access edge.
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              running,
    input  logic              flag,
    output logic              start_req,
    output logic              swrst_req,
    output mode_cfg_t         mode_cfg,
    output logic [CNT_W-1:0]  period,
    output logic              ien,
    output logic              stat_rd,
    output logic [CNT_W-CNT_W/2-1:0] hold
);

    localparam int LO_W = CNT_W / 2;
    localparam int HI_W = CNT_W - LO_W;

    logic            wr_acc;
    logic            rd_acc;
    logic [HI_W-1:0] per_shadow;
    logic            unused_bits;

    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;
    assign unused_bits = ^{bus_wdata, bus_addr};

    // Control pulses: reset wins over start in the same write.
    assign swrst_req = wr_acc && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[CTRL_RST_BIT];
    assign start_req = wr_acc && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[CTRL_GO_BIT]
                       && !bus_wdata[CTRL_RST_BIT];
    assign stat_rd   = rd_acc && (bus_addr == ADDR_W'(OFF_STAT));

    // Configuration registers and two-step period commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_cfg   <= '0;
            period     <= '0;
            per_shadow <= '0;
            ien        <= 1'b0;
        end else if (wr_acc) begin
            if (bus_addr == ADDR_W'(OFF_MODE)) begin
                mode_cfg.cont    <= bus_wdata[MODE_CONT_BIT];
                mode_cfg.alt_src <= bus_wdata[MODE_ALT_BIT];
                mode_cfg.pres    <= bus_wdata[MODE_PRE_LSB +: PRES_W];
            end
            if (bus_addr == ADDR_W'(OFF_PER_HI)) begin
                per_shadow <= bus_wdata[HI_W-1:0];
            end
            if (bus_addr == ADDR_W'(OFF_PER_LO)) begin
                period <= {per_shadow, bus_wdata[LO_W-1:0]};
            end
            if (bus_addr == ADDR_W'(OFF_IEN)) begin
                ien <= bus_wdata[0];
            end
        end
    end

    // High-half latch taken when the low counter word is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (rd_acc && (bus_addr == ADDR_W'(OFF_CNT_LO))) begin
            hold <= cnt[CNT_W-1:LO_W];
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_CTRL): bus_rdata[CTRL_GO_BIT] = running;
            ADDR_W'(OFF_MODE): begin
                bus_rdata[MODE_CONT_BIT]            = mode_cfg.cont;
                bus_rdata[MODE_ALT_BIT]             = mode_cfg.alt_src;
                bus_rdata[MODE_PRE_LSB +: PRES_W]   = mode_cfg.pres;
            end
            ADDR_W'(OFF_PER_LO): bus_rdata[LO_W-1:0] = period[LO_W-1:0];
            ADDR_W'(OFF_PER_HI): bus_rdata[HI_W-1:0] = period[CNT_W-1:LO_W];
            ADDR_W'(OFF_IEN):    bus_rdata[0]        = ien;
            ADDR_W'(OFF_STAT):   bus_rdata[0]        = flag;
            ADDR_W'(OFF_CNT_LO): bus_rdata[LO_W-1:0] = cnt[LO_W-1:0];
            ADDR_W'(OFF_CNT_HI): bus_rdata[HI_W-1:0] = hold;
            default:             bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ivt_prescaler.sv
// Divides the selected source strobe by (pres + 1) into count ticks.
// Assumes the divider restarts from zero whenever the timer is idle.
module ivt_prescaler
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swrst,
    input  logic              running,
    input  logic              src_strobe,
    input  logic [PRES_W-1:0] pres,
    output logic              tick
);

    logic [PRES_W-1:0] div_cnt;

    assign tick = running && src_strobe && (div_cnt >= pres);

    // Strobe counter that wraps on each emitted tick.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst || !running) begin
            div_cnt <= '0;
        end else if (src_strobe) begin
            div_cnt <= tick ? '0 : div_cnt + PRES_W'(1);
        end
    end

endmodule

// File: rtl/ivt_counter.sv
// Main count register, run state and period status flag.
// Assumes tick only asserts while running; start is ignored while running.
module ivt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swrst,
    input  logic             start,
    input  logic             tick,
    input  logic             cont,
    input  logic [CNT_W-1:0] period,
    input  logic             stat_rd,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             flag,
    output logic             evt
);

    assign evt = tick && (cnt == period);

    // Count, wrap or halt on the period match.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else begin
            if (start && !running) begin
                running <= 1'b1;
            end
            if (evt) begin
                cnt <= '0;
                if (!cont) begin
                    running <= 1'b0;
                end
            end else if (tick) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Status flag: a new event beats a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n || swrst) begin
            flag <= 1'b0;
        end else if (evt) begin
            flag <= 1'b1;
        end else if (stat_rd) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/ivt64_timer.sv
// Top of the interval timer: register file, source select, prescaler, counter.
// Assumes both time bases are clock-enable strobes synchronous to clk.
module ivt64_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              periph_tick,
    input  logic              alt_tick,
    output logic              irq
);

    localparam int HI_W = CNT_W - CNT_W / 2;

    logic             start_req;
    logic             swrst_req;
    mode_cfg_t        mode_cfg;
    logic [CNT_W-1:0] period;
    logic             ien;
    logic             stat_rd;
    logic [HI_W-1:0]  hold;
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic             flag;
    logic             evt;
    logic             tick;
    logic             src_strobe;

    ivt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt       (cnt),
        .running   (running),
        .flag      (flag),
        .start_req (start_req),
        .swrst_req (swrst_req),
        .mode_cfg  (mode_cfg),
        .period    (period),
        .ien       (ien),
        .stat_rd   (stat_rd),
        .hold      (hold)
    );

    // Source select between the two time-base strobes.
    assign src_strobe = mode_cfg.alt_src ? alt_tick : periph_tick;

    ivt_prescaler u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .swrst      (swrst_req),
        .running    (running),
        .src_strobe (src_strobe),
        .pres       (mode_cfg.pres),
        .tick       (tick)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .swrst   (swrst_req),
        .start   (start_req),
        .tick    (tick),
        .cont    (mode_cfg.cont),
        .period  (period),
        .stat_rd (stat_rd),
        .cnt     (cnt),
        .running (running),
        .flag    (flag),
        .evt     (evt)
    );

    // Interrupt request: flag gated by its enable.
    assign irq = flag && ien;

endmodule

// File: rtl/ivt64_checker.sv
// Temporal properties of the interval timer, bound into the top module.
module ivt64_checker
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              running,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  period,
    input logic              flag,
    input logic [CNT_W-CNT_W/2-1:0] hold,
    input logic              evt,
    input logic              tick,
    input logic              src_strobe,
    input logic              mode_cont,
    input logic              ien,
    input logic              irq
);

    localparam int LO_W = CNT_W / 2;

    logic rst_wr, hi_wr, lo_rd, st_rd;
    assign rst_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[CTRL_RST_BIT];
    assign hi_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_PER_HI));
    assign lo_rd  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFF_CNT_LO));
    assign st_rd  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFF_STAT));

    a_r11_swrst_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> (!running && cnt == '0 && !flag));

    a_r5_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !mode_cont) |=> !running);

    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_cont && !rst_wr) |=> (running && cnt == '0));

    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !rst_wr) |=> flag);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && !evt) |=> !flag);

    a_r8_hold_latch: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> (hold == $past(cnt[CNT_W-1:LO_W])));

    a_r7_shadow_only: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> $stable(period));

    a_r2_tick_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (src_strobe && running));

    a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);

endmodule

bind ivt64_timer ivt64_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .running    (running),
    .cnt        (cnt),
    .period     (period),
    .flag       (flag),
    .hold       (hold),
    .evt        (evt),
    .tick       (tick),
    .src_strobe (src_strobe),
    .mode_cont  (mode_cfg.cont),
    .ien        (ien),
    .irq        (irq)
);

// File: tb/sim_ivt64_timer.sv
module sim_ivt64_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        periph_tick = 1'b1;
    logic        alt_tick = 1'b0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int edges = 0, alt_cnt = 0, alt_ph = 0;
    int ev_n = 0, ev_edge = 0, ev_alt = 0;
    bit irq_q = 1'b0, irq_any = 1'b0, done = 1'b0;

    ivt64_timer #(.CNT_W(CW), .ADDR_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_tick(periph_tick), .alt_tick(alt_tick), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Edge and alternate-strobe counters.
    always @(posedge clk) begin
        edges++;
        if (alt_tick) alt_cnt++;
    end

    // Alternate strobe once every three cycles; event monitor on irq rise.
    always @(negedge clk) begin
        alt_ph = (alt_ph == 2) ? 0 : alt_ph + 1;
        alt_tick = (alt_ph == 0);
        if (irq) irq_any = 1'b1;
        if (irq && !irq_q) begin
            ev_n++;
            ev_edge = edges;
            ev_alt = alt_cnt;
        end
        irq_q = irq;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(a);
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic wait_ev(input int n0, input string req);
        int guard = 0;
        while (ev_n == n0 && guard < 3000) begin
            @(posedge clk);
            guard++;
        end
        check(ev_n != n0, req, 0, 1);
    endtask

    task automatic setup(input int alt, input int pr, input int p, input int cont, input int en);
        wr('h00, 'h100);
        wr('h04, (pr << 8) | (alt << 3) | cont);
        wr('h0C, (p >> 8) & 'hFF);
        wr('h08, p & 'hFF);
        wr('h10, en);
    endtask

    // One sweep point: event spacing counted in selected strobes.
    task automatic run_case(input int alt, input int pr, input int p, input int cont);
        int s_edge, s_alt, n0, meas, len, d, e1, a1;
        setup(alt, pr, p, cont, 1);
        n0 = ev_n;
        wr('h00, 1);
        s_edge = edges; s_alt = alt_cnt;
        len = (p + 1) * (pr + 1);
        wait_ev(n0, "R3 first event timeout");
        meas = alt ? (ev_alt - s_alt) : (ev_edge - s_edge);
        check(meas == len, alt ? "R6 alt-source spacing" : "R2/R3 first event spacing", meas, len);
        e1 = ev_edge; a1 = ev_alt;
        rd('h1C, d);
        check(d == 1, "R3 status bit0 set", d, 1);
        check(irq == 1'b0, "R9 read clears irq", irq, 0);
        if (cont) begin
            wait_ev(n0 + 1, "R4 second event timeout");
            meas = alt ? (ev_alt - a1) : (ev_edge - e1);
            check(meas == len, "R4 continuous repeat spacing", meas, len);
        end else begin
            repeat (len * 3 + 8) @(posedge clk);
            check(ev_n == n0 + 1, "R5 one-shot single event", ev_n - n0, 1);
            rd('h00, d);
            check(d == 0, "R5 one-shot idle", d, 0);
            rd('h20, d);
            check(d == 0, "R5 one-shot counter zero", d, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 180000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int d, s, r, exp_v, n0;
        int offs[8] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h1C, 'h20, 'h24};
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state.
        check(irq == 1'b0, "R1 irq low", irq, 0);
        foreach (offs[i]) begin
            rd(offs[i], d);
            check(d == 0, "R1 register zero", d, 0);
        end

        // R2 R3 R5 sweep: one-shot on peripheral strobe.
        for (int pr = 0; pr < 4; pr++)
            for (int p = 0; p < 6; p++)
                run_case(0, pr, p, 0);
        // R4 continuous on peripheral strobe.
        for (int pr = 0; pr < 4; pr++)
            for (int p = 2; p < 6; p++)
                run_case(0, pr, p, 1);
        // R6 alternate source, both modes.
        for (int pr = 0; pr < 2; pr++)
            for (int p = 0; p < 4; p++) begin
                run_case(1, pr, p, 0);
                run_case(1, pr, p, 1);
            end
        // R2 largest prescaler.
        run_case(0, 15, 1, 0);

        // R7 high-word write alone leaves the period untouched.
        setup(0, 0, 3, 0, 1);
        wr('h0C, 1);
        rd('h0C, d);
        check(d == 0, "R7 high readback unchanged", d, 0);
        n0 = ev_n;
        wr('h00, 1);
        s = edges;
        wait_ev(n0, "R7 event timeout");
        check(ev_edge - s == 4, "R7 old period active", ev_edge - s, 4);
        wr('h08, 3);
        rd('h0C, d);
        check(d == 1, "R7 commit on low write", d, 1);

        // R10 masked interrupt.
        setup(0, 0, 2, 0, 0);
        irq_any = 1'b0;
        wr('h00, 1);
        repeat (12) @(posedge clk);
        check(irq_any == 1'b0, "R10 masked irq stays low", irq_any, 0);
        rd('h1C, d);
        check(d == 1, "R10 flag set while masked", d, 1);

        // R9 status read on the same edge as a new event.
        setup(0, 0, 3, 1, 1);
        n0 = ev_n;
        wr('h00, 1);
        wait_ev(n0, "R9 event timeout");
        repeat (2) @(posedge clk);
        rd('h1C, d);
        check(d == 1, "R9 coincident read value", d, 1);
        check(irq == 1'b1, "R9 coincident event keeps flag", irq, 1);
        rd('h1C, d);
        check(irq == 1'b0, "R9 later read clears", irq, 0);

        // R8 atomic split readback across a low-half carry.
        setup(0, 0, 'hFFFF, 1, 0);
        wr('h00, 1);
        s = edges;
        repeat (250) @(posedge clk);
        rd('h20, d);
        r = edges;
        exp_v = r - 1 - s;
        check(d == (exp_v & 'hFF), "R8 low word", d, exp_v & 'hFF);
        repeat (300) @(posedge clk);
        rd('h24, d);
        check(d == ((exp_v >> 8) & 'hFF), "R8 high word from latch", d, (exp_v >> 8) & 'hFF);
        rd('h24, d);
        check(d == ((exp_v >> 8) & 'hFF), "R8 latch stable", d, (exp_v >> 8) & 'hFF);

        // R11 software reset while running.
        wr('h00, 'h100);
        rd('h00, d);
        check(d == 0, "R11 stopped", d, 0);
        repeat (40) @(posedge clk);
        rd('h20, d);
        check(d == 0, "R11 counter cleared and held", d, 0);
        rd('h04, d);
        check(d == 1, "R11 mode kept", d, 1);
        wr('h00, 'h101);
        repeat (5) @(posedge clk);
        rd('h00, d);
        check(d == 0, "R11 reset beats start", d, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule